// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken by combining two direction predictors. A per-branch predictor keeps a table of 2-bit counters selected by a hash of the branch address. A history-based predictor keeps a table of 2-bit counters selected by a register holding the most recent resolved branch outcomes. A third table of 2-bit counters, also selected by branch address, learns for each branch which of the two has been more accurate recently and picks that one's answer.

The lookup side is combinational. The fetch logic presents a PC and, in the same cycle, receives the final direction, both component directions and the current history value. That history value travels with the branch down the pipeline. When the branch resolves, the update side presents the PC, the saved history and the real outcome. All three tables are trained at the next clock edge, and the history register shifts in the outcome.

Top module: `tournament_bp`

## Requirements
- R1: While reset is asserted, every counter in all three tables is set to 01 and the history register is set to zero. After reset, every lookup returns 0 on `pred_taken`, `pred_local` and `pred_global`, and 0 on `pred_hist`.
- R2: Address-indexed counters are selected by an index whose bit k is the XOR of every PC bit i with i mod LIDX_W equal to k. On each valid update, the selected counter counts up on taken, saturating at 11, and down on not taken, saturating at 00. `pred_local` is the upper bit of the counter selected by `pred_pc`.
- R3: On update, the history-indexed counter at entry `upd_hist` is trained with the same saturating rule. `pred_global` is the upper bit of the counter at entry `pred_hist`.
- R4: `pred_hist` shows the history register. Each valid update shifts it left by one place, with `upd_taken` entering at bit 0.
- R5: `pred_taken` equals `pred_global` when the upper bit of the chooser counter for `pred_pc` is 1, and equals `pred_local` otherwise.
- R6: On update, the chooser counter changes only when the two component predictions, read at the update indices, differ. It counts up, saturating, when the global component was correct, and counts down, saturating, when the local component was correct.
- R7: Both component tables are trained on every valid update, whichever component the chooser favours.
- R8: When `upd_valid` is 0, no table entry and no history bit changes.
- R9: When a lookup and an update fall in the same cycle, the lookup returns values from the state before that update. The new state is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Final predicted direction |
| pred_local | output | 1 | Address-indexed component direction |
| pred_global | output | 1 | History-indexed component direction |
| pred_hist | output | HIST_W | History snapshot to carry with the branch |
| upd_valid | input | 1 | A resolved branch is presented for training |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History snapshot taken when the branch was predicted |
| upd_taken | input | 1 | Resolved outcome, 1 for taken |

## Verification
A lookup and a training update can occur in the same cycle, and they may hit the same table entries. The bench provokes this on purpose. It applies an update while it looks up the same PC and the entry that the history selects. It checks that the outputs still match the state before the update, and that they show the trained state one cycle later. Random traffic mixes saved and unrelated history snapshots with addresses that alias in the tables. Every cycle, the outputs are compared against a bench model whose tables advance only at the clock edge.

// File: rtl/tournament_bp.sv
module tournament_bp #(
  parameter int PC_W   = 32,
  parameter int LIDX_W = 6,
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic              pred_local,
  output logic              pred_global,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken
);
  localparam int LSZ = 1 << LIDX_W;
  localparam int GSZ = 1 << HIST_W;

  logic [1:0] loc_t [LSZ];
  logic [1:0] glb_t [GSZ];
  logic [1:0] cho_t [LSZ];
  logic [HIST_W-1:0] ghr;

  function automatic logic [LIDX_W-1:0] fold(input logic [PC_W-1:0] pc);
    logic [LIDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < PC_W; i++) r[i % LIDX_W] ^= pc[i];
    return r;
  endfunction

  function automatic logic [1:0] bump(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  wire [LIDX_W-1:0] p_li = fold(pred_pc);
  wire [LIDX_W-1:0] u_li = fold(upd_pc);

  assign pred_hist   = ghr;
  assign pred_local  = loc_t[p_li][1];
  assign pred_global = glb_t[ghr][1];
  assign pred_taken  = cho_t[p_li][1] ? pred_global : pred_local;

  wire [1:0] lc = loc_t[u_li];
  wire [1:0] gc = glb_t[upd_hist];
  wire [1:0] cc = cho_t[u_li];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LSZ; i++) begin
        loc_t[i] <= 2'b01;
        cho_t[i] <= 2'b01;
      end
      for (int i = 0; i < GSZ; i++) glb_t[i] <= 2'b01;
      ghr <= '0;
    end else if (upd_valid) begin
      loc_t[u_li]     <= bump(lc, upd_taken);
      glb_t[upd_hist] <= bump(gc, upd_taken);
      if (lc[1] != gc[1]) cho_t[u_li] <= bump(cc, gc[1] == upd_taken);
      ghr <= {ghr[HIST_W-2:0], upd_taken};
    end
  end
endmodule

// File: rtl/tournament_bp_chk.sv
module tournament_bp_chk #(
  parameter int HIST_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [HIST_W-1:0] pred_hist,
  input logic              pred_local,
  input logic              pred_global,
  input logic              pred_taken
);
  // R1
  hist_reset_chk: assert property (@(posedge clk) !rst_n |=> pred_hist == '0);

  // R4
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(upd_taken)});

  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(pred_hist));

  // R5
  agree_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_local == pred_global) |-> (pred_taken == pred_local));
endmodule

bind tournament_bp tournament_bp_chk #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .pred_hist(pred_hist), .pred_local(pred_local), .pred_global(pred_global),
  .pred_taken(pred_taken)
);

// File: tb/sim_tournament_bp.sv
module sim_tournament_bp;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32, LIDX_W = 6, HIST_W = 6;
  localparam int LSZ = 1 << LIDX_W, GSZ = 1 << HIST_W;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic [HIST_W-1:0] upd_hist = '0;
  logic upd_valid = 0, upd_taken = 0;
  logic pred_taken, pred_local, pred_global;
  logic [HIST_W-1:0] pred_hist;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [1:0] m_loc [LSZ];
  logic [1:0] m_glb [GSZ];
  logic [1:0] m_cho [LSZ];
  logic [HIST_W-1:0] m_ghr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tournament_bp #(.PC_W(PC_W), .LIDX_W(LIDX_W), .HIST_W(HIST_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_local(pred_local), .pred_global(pred_global), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken));

  function automatic logic [LIDX_W-1:0] idx(input logic [PC_W-1:0] pc);
    logic [LIDX_W-1:0] r = '0;
    for (int i = 0; i < PC_W; i++) r[i % LIDX_W] ^= pc[i];
    return r;
  endfunction

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 3) ? c : c + 1;
    return (c == 0) ? c : c - 1;
  endfunction

  task automatic chk(input string req, input logic [HIST_W-1:0] act, input logic [HIST_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < LSZ; i++) begin m_loc[i] = 1; m_cho[i] = 1; end
    for (int i = 0; i < GSZ; i++) m_glb[i] = 1;
    m_ghr = '0;
  endtask

  task automatic m_upd(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h, input logic t);
    logic [LIDX_W-1:0] li = idx(pc);
    logic l = m_loc[li][1], g = m_glb[h][1];
    m_loc[li] = sat(m_loc[li], t);
    m_glb[h]  = sat(m_glb[h], t);
    if (l != g) m_cho[li] = sat(m_cho[li], g == t);
    m_ghr = {m_ghr[HIST_W-2:0], t};
  endtask

  task automatic check_all();
    logic [LIDX_W-1:0] li = idx(pred_pc);
    logic el = m_loc[li][1], eg = m_glb[m_ghr][1];
    chk("R2", pred_local, el);
    chk("R3", pred_global, eg);
    chk("R4", pred_hist, m_ghr);
    chk("R5", pred_taken, m_cho[li][1] ? eg : el);
  endtask

  // drive at negedge, compare after settling, advance model before posedge
  task automatic step(input logic v, input logic [PC_W-1:0] upc, input logic [HIST_W-1:0] h,
                      input logic t, input logic [PC_W-1:0] ppc);
    @(negedge clk);
    upd_valid = v; upd_pc = upc; upd_hist = h; upd_taken = t; pred_pc = ppc;
    #1;
    check_all();
    if (v) m_upd(upc, h, t);
  endtask

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    pred_pc = 5; #1;
    chk("R1", pred_taken, 0); chk("R1", pred_local, 0);
    chk("R1", pred_global, 0); chk("R1", pred_hist, 0);

    // R2: counter climbs, aliased PC (5 ^ (1<<6) folds to 4) hits a different entry
    step(1, 5, 0, 1, 5);
    step(0, 0, 0, 0, 5);
    chk("R2", pred_local, 1);
    pred_pc = 32'h45; #1; chk("R2", pred_local, 0);

    // R6/R7: train history entry 63 taken, then disagreement at pc 3
    m_reset(); @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    step(1, 10, 6'h3F, 1, 0);
    step(1, 10, 6'h3F, 1, 0);
    step(1, 3, 6'h3F, 1, 3);
    step(0, 0, 0, 0, 3);
    chk("R6", pred_taken, 0);
    chk("R7", pred_local, 1);
    chk("R4", pred_hist, 6'h07);

    // R8: invalid update changes nothing
    step(0, 3, 6'h07, 0, 3);
    step(0, 3, 6'h07, 0, 3);
    chk("R8", pred_local, 1); chk("R8", pred_hist, 6'h07); chk("R8", pred_taken, 0);

    // R9: update same entries as the lookup in the same cycle
    @(negedge clk);
    upd_valid = 1; upd_pc = 3; upd_hist = 6'h07; upd_taken = 1; pred_pc = 3; #1;
    chk("R9", pred_global, 0); chk("R9", pred_hist, 6'h07); chk("R9", pred_local, 1);
    m_upd(3, 6'h07, 1);
    @(negedge clk); upd_valid = 0; #1;
    chk("R9", pred_hist, 6'h0F); chk("R9", pred_local, 1);
    check_all();

    // random traffic
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      logic [PC_W-1:0] a = $urandom % 24;
      if ($urandom % 4 == 0) a = a | (32'h1 << ($urandom % 32));
      step($urandom % 4 != 0, a,
           ($urandom % 2) ? pred_hist : HIST_W'($urandom),
           $urandom % 3 != 0, $urandom % 24);
    end
    @(negedge clk); upd_valid = 0; #1; check_all();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule